// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This unit watches a bank of general-purpose input pins, brings each one into the clock domain through a two-stage synchronizer, and spots level transitions. Each pin has its own enable for rising transitions and its own enable for falling transitions. A transition of an enabled type latches a sticky status bit for that pin. The bit holds until software writes a one to it.

The status bits drive the interrupt outputs. Each of the low pins has its own interrupt line. The remaining upper pins share one group line, which is high while any of their status bits is set. Software reaches three 32-bit words through a single-cycle bus: the rising enables, the falling enables and the status. The enables reset to zero, so nothing is detected until software turns it on.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset both enable words and the status word read zero, and every interrupt output is low.
- R2: A low-to-high transition on pin i whose rising enable bit i is one sets status bit i and no other bit.
- R3: A high-to-low transition on pin i whose falling enable bit i is one sets status bit i and no other bit.
- R4: A transition whose type is not enabled for that pin leaves its status bit clear. When both enables are one, a transition in either direction sets the bit.
- R5: A set status bit stays set over later clock cycles and later pin transitions until it is cleared.
- R6: A write to the status word clears each bit written as one. Bits written as zero keep their value.
- R7: If a qualifying transition and a write-one clear of the same bit fall in the same cycle, the bit ends up set.
- R8: Interrupt line irq_pin[i] is high exactly when status bit i is set, for i from 0 to 10.
- R9: irq_group is high exactly when at least one status bit from 11 to 27 is set.
- R10: Register map on reg_addr: 0 is the rising enables, 1 is the falling enables, 2 is the status, and 3 reads zero. Enable bits read back as written. Bits 31 to 28 of every word read zero.
- R11: A pin transition made between clock edges shows in the status on the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 28 | Asynchronous input pins |
| reg_addr | input | 2 | Word select |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| irq_pin | output | 11 | Per-pin interrupts for pins 0 to 10 |
| irq_group | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
The assertions assume that reg_addr, reg_we and reg_wdata are driven to known values in every cycle. They also assume that a status bit can become set only from a transition already registered inside the synchronizer. The stimulus changes pins and bus signals only on falling clock edges. It holds each pin level for several cycles, so every transition passes through the synchronizer as one clean edge. The only case where a transition and a clear land in the same cycle is the R7 case, and it is placed there on purpose by counting edges.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 28,
  parameter int NSOLO = 11,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [NSOLO-1:0] irq_pin,
  output logic             irq_group
);
  localparam logic [1:0] A_RISE = 2'd0;
  localparam logic [1:0] A_FALL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NPINS-1:0] rise_en_q, fall_en_q, status_q;
  logic [NPINS-1:0] hit, clr;

  assign hit = (sync2_q & ~prev_q & rise_en_q) | (~sync2_q & prev_q & fall_en_q);
  assign clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_RISE) rise_en_q <= reg_wdata[NPINS-1:0];
      if (reg_addr == A_FALL) fall_en_q <= reg_wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | hit;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RISE:  reg_rdata[NPINS-1:0] = rise_en_q;
      A_FALL:  reg_rdata[NPINS-1:0] = fall_en_q;
      A_STAT:  reg_rdata[NPINS-1:0] = status_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_pin   = status_q[NSOLO-1:0];
  assign irq_group = |status_q[NPINS-1:NSOLO];
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NPINS = 28,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_we,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en,
  input logic [NPINS-1:0] syn,
  input logic [NPINS-1:0] prev,
  input logic [NPINS-1:0] status
);
  logic [NPINS-1:0] cmask, qual;
  assign cmask = (reg_we && reg_addr == 2'd2) ? reg_wdata[NPINS-1:0] : '0;
  assign qual  = (syn & ~prev & rise_en) | (~syn & prev & fall_en);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~cmask)) == $past(status & ~cmask)));

  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(qual)) == '0));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(qual) & ~status) == '0));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (reg_rdata[DW-1:NPINS] == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rise_en(rise_en_q),
  .fall_en(fall_en_q), .syn(sync2_q), .prev(prev_q), .status(status_q)
);

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
  localparam int CLK_NS = 10;
  localparam int NP = 28;
  localparam int NS = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] irq_pin;
  logic irq_group;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_edge_irq u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pin(irq_pin), .irq_group(irq_group));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_stat(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(2'd2, d);
    chk({tag, " status"}, d, exp);
    chk("R8 irq_pin", {21'd0, irq_pin}, exp & 32'h7FF);
    chk("R9 irq_group", {31'd0, irq_group}, {31'd0, |exp[NP-1:NS]});
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(2'd0, d); chk("R1 rise enables", d, 0);
    rd(2'd1, d); chk("R1 fall enables", d, 0);
    chk_stat("R1", 0);
    // R10 map and reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hA5A5_A5A5);
    rd(2'd0, d); chk("R10 rise readback", d, 32'h0FFF_FFFF);
    rd(2'd1, d); chk("R10 fall readback", d, 32'h05A5_A5A5);
    rd(2'd3, d); chk("R10 unmapped", d, 0);
    chk_stat("R10 enables do not touch", 0);

    // sweep every pin and every enable combination
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bit_i;
        bit_i = 32'd1 << i;
        wr(2'd0, m[0] ? 32'hFFFF_FFFF : 32'h0);
        wr(2'd1, m[1] ? 32'hFFFF_FFFF : 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        chk_stat("R6 cleared", 0);
        pin_in[i] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk_stat("R11 not yet", 0);
        @(negedge clk);
        chk_stat(m[0] ? "R2 rise" : "R4 rise disabled", m[0] ? bit_i : 0);
        repeat (4) @(negedge clk);
        wr(2'd2, 32'h0);
        chk_stat("R6 zero write R5 sticky", m[0] ? bit_i : 0);
        wr(2'd2, 32'hFFFF_FFFF);
        chk_stat("R6 clear", 0);
        pin_in[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk_stat(m[1] ? "R3 fall" : "R4 fall disabled", m[1] ? bit_i : 0);
        if (m == 1) begin
          pin_in[i] = 1'b1;
          repeat (5) @(negedge clk);
          pin_in[i] = 1'b0;
          repeat (5) @(negedge clk);
          chk_stat("R5 sticky over transitions", bit_i);
        end
      end
    end

    // R7: clear and set in the same cycle
    wr(2'd0, 32'h0000_0020);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    pin_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_addr = 2'd2; reg_we = 1'b1; reg_wdata = 32'h0000_0020;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    chk_stat("R7 set beats clear", 32'h0000_0020);
    wr(2'd2, 32'h0000_0020);
    chk_stat("R7 later clear", 0);
    pin_in[5] = 1'b0;

    // R9: two group pins, partial clear
    wr(2'd0, 32'h0FFF_FFFF);
    repeat (3) @(negedge clk);
    pin_in[12] = 1'b1; pin_in[27] = 1'b1; pin_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk_stat("R9 multi", 32'h0800_1008);
    wr(2'd2, 32'h0000_1000);
    chk_stat("R9 partial clear", 32'h0800_0008);
    wr(2'd2, 32'h0800_0000);
    chk_stat("R9 group drop", 32'h0000_0008);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule